// File: doc/BRIEF.md
# Selectable-Width I/Q Byte Packer

This block sits between a decimating receive chain and a byte-wide host link with a fixed byte budget. It accepts one complex baseband sample per handshake, a signed 16-bit in-phase component and a signed 16-bit quadrature component. It narrows both components to a width chosen at run time, then sends the result out one byte per handshake. Three widths are offered: 16, 12 and 8 bits per component. A complex sample therefore costs 4, 3 or 2 bytes on the link.

At 32 Mbyte/s this gives complex sample rates of 8, about 10.67 and 16 Msamples/s. The narrower formats trade dynamic range for more passband bandwidth. Narrowing keeps the top bits of each component by an arithmetic right shift. The result is rounded toward minus infinity, the sign is kept, and no rounding or saturation is applied.

Both sides use valid/ready. While a sample's bytes are still draining, the input is held off, so backpressure on the byte side throttles the sample side without losing or repeating data.

Top module: `iq_byte_packer`

## Requirements
- R1: Format code 2'b00 (16-bit) sends four bytes per sample, in this order: I[7:0], I[15:8], Q[7:0], Q[15:8].
- R2: Format code 2'b01 (12-bit) forms I12 = I >>> 4 and Q12 = Q >>> 4. It sends three bytes per sample: I12[7:0], then {Q12[3:0], I12[11:8]}, then Q12[11:4].
- R3: Format code 2'b10 (8-bit) sends two bytes per sample: I[15:8], then Q[15:8].
- R4: Format code 2'b11 is handled exactly like the 16-bit format.
- R5: Narrowing rounds toward minus infinity and keeps the sign. For example, 16'hFFFF becomes 12'hFFF, 16'h8000 becomes 12'h800, and 16'hFFEF becomes 8'hFF.
- R6: In the 16-bit format, a raw converter word that holds a 12-bit value with its upper four bits zero (for example 16'h0ABC) comes out unchanged, as bytes 8'hBC then 8'h0A.
- R7: When samples arrive back to back and out_ready stays high, bytes leave on consecutive cycles with no idle cycle. The byte count is exactly 4, 3 or 2 per sample for the 16-, 12- and 8-bit formats.
- R8: The format is captured when a sample is accepted. A change to fmt_sel while a sample is draining affects only later samples.
- R9: in_ready is low while a sample is draining, except in the cycle when its final byte is taken. A new sample may be accepted in that cycle. Under any out_ready pattern, no sample is dropped or duplicated.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_byte holds its value on the next cycle.
- R11: A synchronous reset empties the block: out_valid goes low and in_ready goes high. out_valid then stays low until the first sample is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_sel | input | 2 | Width selection: 00 = 16-bit, 01 = 12-bit, 10 = 8-bit, 11 = 16-bit |
| in_valid | input | 1 | Sample-side valid |
| in_ready | output | 1 | Sample-side ready |
| in_i | input | 16 | In-phase component, signed |
| in_q | input | 16 | Quadrature component, signed |
| out_valid | output | 1 | Byte-side valid |
| out_ready | input | 1 | Byte-side ready |
| out_byte | output | 8 | Current output byte |

## Verification
The hardest case to reach is the last-byte cycle in which a new sample is taken while the byte side is stalling at irregular points. A slip there would duplicate or drop a whole sample rather than a single byte. The stimulus offers samples continuously, with the format rotating, while out_ready follows a pattern whose period does not divide 4, 3 or 2. Stalls therefore land on every byte position, including the one where the next sample is accepted. A scoreboard holds the expected bytes, and stalls are checked for held data. A separate run with out_ready held high counts bytes and cycles for each format. This confirms the 4:3:2 byte cost and shows there are no idle cycles.

// File: rtl/iq_pack_pkg.sv
package iq_pack_pkg;

   typedef enum logic [1:0] {
      FMT_FULL   = 2'b00,
      FMT_MID    = 2'b01,
      FMT_NARROW = 2'b10,
      FMT_ALT    = 2'b11
   } pack_fmt_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/iq_lane_reduce.sv
module iq_lane_reduce #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 12
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);

   if (OUT_W > IN_W) begin : g_bad_width
      $error("iq_lane_reduce: OUT_W must not exceed IN_W");
   end

   if (OUT_W == IN_W) begin : g_pass
      assign dout = din;
   end else begin : g_shift
      logic signed [IN_W-1:0] shifted;
      logic                   lane_unused;
      assign shifted     = $signed(din) >>> (IN_W - OUT_W);
      assign dout        = shifted[OUT_W-1:0];
      assign lane_unused = ^shifted[IN_W-1:OUT_W];
   end

endmodule

// File: rtl/iq_frame_builder.sv
module iq_frame_builder
   import iq_pack_pkg::*;
#(
   parameter int COMP_W   = 16,
   parameter int MID_W    = 12,
   parameter int NARROW_W = 8,
   parameter int BYTE_W   = 8,
   parameter int FRAME_W  = 2 * COMP_W,
   parameter int CNT_W    = 3
) (
   input  logic [1:0]         fmt,
   input  logic [COMP_W-1:0]  comp_i,
   input  logic [COMP_W-1:0]  comp_q,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   nbytes
);

   localparam int FULL_N   = ceil_div(2 * COMP_W, BYTE_W);
   localparam int MID_N    = ceil_div(2 * MID_W, BYTE_W);
   localparam int NARROW_N = ceil_div(2 * NARROW_W, BYTE_W);

   logic [COMP_W-1:0]   comps  [2];
   logic [MID_W-1:0]    mid    [2];
   logic [NARROW_W-1:0] narrow [2];

   assign comps[0] = comp_i;
   assign comps[1] = comp_q;

   for (genvar ln = 0; ln < 2; ln++) begin : g_lane
      iq_lane_reduce #(.IN_W(COMP_W), .OUT_W(MID_W)) u_mid (
         .din  (comps[ln]),
         .dout (mid[ln])
      );
      iq_lane_reduce #(.IN_W(COMP_W), .OUT_W(NARROW_W)) u_narrow (
         .din  (comps[ln]),
         .dout (narrow[ln])
      );
   end

   always_comb begin
      case (pack_fmt_e'(fmt))
         FMT_MID: begin
            frame  = FRAME_W'({mid[1], mid[0]});
            nbytes = CNT_W'(MID_N);
         end
         FMT_NARROW: begin
            frame  = FRAME_W'({narrow[1], narrow[0]});
            nbytes = CNT_W'(NARROW_N);
         end
         default: begin
            frame  = {comps[1], comps[0]};
            nbytes = CNT_W'(FULL_N);
         end
      endcase
   end

endmodule

// File: rtl/iq_byte_serializer.sv
module iq_byte_serializer #(
   parameter int FRAME_W = 32,
   parameter int BYTE_W  = 8,
   parameter int CNT_W   = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               s_valid,
   output logic               s_ready,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic [CNT_W-1:0]   nbytes_in,
   output logic               m_valid,
   input  logic               m_ready,
   output logic [BYTE_W-1:0]  m_data
);

   localparam int LANES = FRAME_W / BYTE_W;
   localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

   if (FRAME_W % BYTE_W != 0) begin : g_bad_frame
      $error("iq_byte_serializer: FRAME_W must be a multiple of BYTE_W");
   end
   if ((1 << CNT_W) <= LANES) begin : g_bad_cnt
      $error("iq_byte_serializer: CNT_W too narrow for lane count");
   end

   logic               busy;
   logic [CNT_W-1:0]   idx;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] hold;
   logic               at_last;
   logic               take;
   logic               fire;
   logic [BYTE_W-1:0]  lane [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane[k] = hold[k*BYTE_W +: BYTE_W];
   end

   assign at_last = busy && (idx == cnt - 1'b1);
   assign m_valid = busy;
   assign s_ready = !busy || (m_ready && at_last);
   assign take    = s_valid && s_ready;
   assign fire    = busy && m_ready;
   assign m_data  = lane[idx[SEL_W-1:0]];

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         idx  <= '0;
         cnt  <= '0;
         hold <= '0;
      end else if (take) begin
         busy <= 1'b1;
         idx  <= '0;
         cnt  <= nbytes_in;
         hold <= frame_in;
      end else if (fire) begin
         if (at_last) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R10: a stalled byte is held
   assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

   // R9: an accepted sample starts at its first byte with its own length
   assert_load_start_R9: assert property (@(posedge clk) disable iff (rst)
      (s_valid && s_ready) |=> (m_valid && idx == '0 && cnt == $past(nbytes_in)));

   // R8: byte count of a draining sample never changes
   assert_fmt_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (m_valid && !s_ready) |=> $stable(cnt));

   // R7: byte index stays inside the sample
   assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
      m_valid |-> (idx < cnt));

   // R11: with nothing offered, an idle output stays idle
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      (!m_valid && !s_valid) |=> !m_valid);

endmodule

// File: rtl/iq_byte_packer.sv
module iq_byte_packer
   import iq_pack_pkg::*;
#(
   parameter int COMP_W   = 16,
   parameter int MID_W    = 12,
   parameter int NARROW_W = 8,
   parameter int BYTE_W   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        fmt_sel,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [COMP_W-1:0] in_i,
   input  logic [COMP_W-1:0] in_q,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_byte
);

   localparam int FRAME_W = 2 * COMP_W;
   localparam int LANES   = ceil_div(FRAME_W, BYTE_W);
   localparam int CNT_W   = $clog2(LANES + 1);

   if ((2 * COMP_W) % BYTE_W != 0) begin : g_bad_full
      $error("iq_byte_packer: full sample must fill whole bytes");
   end
   if ((2 * MID_W) % BYTE_W != 0) begin : g_bad_mid
      $error("iq_byte_packer: mid sample must fill whole bytes");
   end
   if ((2 * NARROW_W) % BYTE_W != 0) begin : g_bad_narrow
      $error("iq_byte_packer: narrow sample must fill whole bytes");
   end
   if (!(NARROW_W < MID_W && MID_W < COMP_W)) begin : g_bad_order
      $error("iq_byte_packer: widths must satisfy NARROW_W < MID_W < COMP_W");
   end

   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbytes;

   iq_frame_builder #(
      .COMP_W   (COMP_W),
      .MID_W    (MID_W),
      .NARROW_W (NARROW_W),
      .BYTE_W   (BYTE_W),
      .FRAME_W  (FRAME_W),
      .CNT_W    (CNT_W)
   ) u_build (
      .fmt    (fmt_sel),
      .comp_i (in_i),
      .comp_q (in_q),
      .frame  (frame),
      .nbytes (nbytes)
   );

   iq_byte_serializer #(
      .FRAME_W (FRAME_W),
      .BYTE_W  (BYTE_W),
      .CNT_W   (CNT_W)
   ) u_ser (
      .clk       (clk),
      .rst       (rst),
      .s_valid   (in_valid),
      .s_ready   (in_ready),
      .frame_in  (frame),
      .nbytes_in (nbytes),
      .m_valid   (out_valid),
      .m_ready   (out_ready),
      .m_data    (out_byte)
   );

endmodule

// File: tb/tb_iq_byte_packer.sv
module tb_iq_byte_packer;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  fmt_sel = 2'b00;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_i = '0;
   logic [15:0] in_q = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_byte;

   iq_byte_packer dut (
      .clk       (clk),
      .rst       (rst),
      .fmt_sel   (fmt_sel),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_i      (in_i),
      .in_q      (in_q),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_byte  (out_byte)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int byte_cnt = 0;
   int first_cyc = 0;
   int last_cyc = 0;
   int pushed = 0;
   int popped = 0;
   bit bp_on = 1'b0;
   bit done = 1'b0;
   bit prev_stall = 1'b0;
   logic [7:0] prev_byte = '0;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   always @(posedge clk) cyc <= cyc + 1;

   // byte-side ready pattern; period 15 does not divide 4, 3 or 2
   always @(negedge clk) begin
      if (bp_on) out_ready = ((cyc % 3) != 2) && ((cyc % 5) != 0);
      else       out_ready = 1'b1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push_exp(input logic [1:0] f, input logic [15:0] i,
                           input logic [15:0] q, input string tag);
      logic [11:0] i12;
      logic [11:0] q12;
      i12 = i[15:4];
      q12 = q[15:4];
      case (f)
         2'b01: begin
            exp_q.push_back(i12[7:0]);
            exp_q.push_back({q12[3:0], i12[11:8]});
            exp_q.push_back(q12[11:4]);
            repeat (3) tag_q.push_back(tag);
            pushed += 3;
         end
         2'b10: begin
            exp_q.push_back(i[15:8]);
            exp_q.push_back(q[15:8]);
            repeat (2) tag_q.push_back(tag);
            pushed += 2;
         end
         default: begin
            exp_q.push_back(i[7:0]);
            exp_q.push_back(i[15:8]);
            exp_q.push_back(q[7:0]);
            exp_q.push_back(q[15:8]);
            repeat (4) tag_q.push_back(tag);
            pushed += 4;
         end
      endcase
   endtask

   task automatic send(input logic [1:0] f, input logic [15:0] i,
                       input logic [15:0] q, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_i     = i;
      in_q     = q;
      fmt_sel  = f;
      forever begin
         #2;
         if (in_ready) break;
         @(negedge clk);
      end
      push_exp(f, i, q, tag);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      #2;
      if (!rst) begin
         if (prev_stall) begin
            check(out_valid && out_byte == prev_byte, "R10", "stalled byte held",
                  {out_valid, out_byte}, {1'b1, prev_byte});
         end
         if (out_valid && !out_ready) begin
            check(!in_ready, "R9", "in_ready during stall", in_ready, 0);
         end
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected byte", out_byte, 0);
            end else begin
               logic [7:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               popped++;
               check(out_byte == e, t, "byte value", out_byte, e);
            end
            byte_cnt++;
            if (byte_cnt == 1) first_cyc = cyc;
            last_cyc = cyc;
         end
         prev_stall = out_valid && !out_ready;
         prev_byte  = out_byte;
      end
   end

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   int bpc [3] = '{4, 3, 2};

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #2;
      check(!out_valid, "R11", "out_valid after reset", out_valid, 0);
      check(in_ready, "R11", "in_ready after reset", in_ready, 1);
      repeat (5) @(negedge clk);
      #2;
      check(!out_valid, "R11", "out_valid idle", out_valid, 0);

      send(2'b00, 16'h1234, 16'hABCD, "R1");
      send(2'b00, 16'h8001, 16'h7FFE, "R1");
      send(2'b00, 16'h0ABC, 16'h0123, "R6");
      send(2'b11, 16'h5A6B, 16'hC3D4, "R4");
      send(2'b01, 16'h1234, 16'hABCD, "R2");
      send(2'b01, 16'h7FF0, 16'h0019, "R2");
      send(2'b10, 16'h1234, 16'hABCD, "R3");
      send(2'b01, 16'hFFFF, 16'h8000, "R5");
      send(2'b10, 16'hFFEF, 16'h000F, "R5");
      drain();

      // R7: byte cost per sample and no idle cycle, per format
      for (int m = 0; m < 3; m++) begin
         byte_cnt = 0;
         for (int s = 0; s < 6; s++)
            send(m[1:0], 16'(16'h1111 * (s + 1)), 16'(16'h0F0F ^ (s * 97)), "R7");
         drain();
         check(byte_cnt == 6 * bpc[m], "R7", "bytes per 6 samples", byte_cnt, 6 * bpc[m]);
         check(last_cyc - first_cyc + 1 == 6 * bpc[m], "R7", "cycle span",
               last_cyc - first_cyc + 1, 6 * bpc[m]);
      end

      // R8: format change while a sample drains
      send(2'b00, 16'hCAFE, 16'hBEEF, "R8");
      @(negedge clk);
      #1;
      fmt_sel = 2'b10;
      @(negedge clk);
      #1;
      fmt_sel = 2'b01;
      send(2'b10, 16'h4321, 16'h8765, "R8");
      send(2'b01, 16'h9ABC, 16'hDEF0, "R8");
      drain();

      // R9 / R10: irregular backpressure with rotating formats
      bp_on = 1'b1;
      for (int s = 0; s < 24; s++)
         send(2'(s % 4), 16'(16'h3C5A + s * 16'h0911), 16'(16'hA5C3 - s * 16'h0373), "R9");
      drain();
      bp_on = 1'b0;
      repeat (2) @(negedge clk);

      check(exp_q.size() == 0 && pushed == popped, "R9", "all bytes delivered once",
            popped, pushed);
      #2;
      check(!out_valid, "R11", "idle after traffic", out_valid, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule